// File: doc/BRIEF.md
# Two-Level Priority Frame Scheduler

This block stores frame descriptors in a set of frame queues and hands them out on request. Each frame queue belongs to one of eight work queues, and each work queue keeps an ordered list of the frame queues that currently hold at least one frame. A dequeue request takes the highest-priority work queue that is not empty. It then takes one frame from the frame queue at the head of that work queue's list and rotates that frame queue to the back of the list.

Enqueues are checked against per-group occupancy limits. Each frame queue is mapped to a congestion group. An enqueue is refused, and nothing is stored, when its group has already reached its threshold or when the frame queue's own storage is full. The frame-queue-to-work-queue map, the frame-queue-to-group map and the group thresholds are parameters.

Top module: `wq_sched`

## Requirements
- R1: After reset, or a reset in mid-run, all queues are empty and `enq_drop`, `deq_ack` and `deq_valid` are low.
- R2: Work queue 0 has the highest priority and work queue 7 the lowest. A work queue is served only when every work queue of higher priority is empty.
- R3: Within a work queue, each dequeue takes one frame from the head frame queue. That frame queue then moves to the tail if it still holds frames.
- R4: Frames of one frame queue are returned in the order in which they were accepted.
- R5: A frame queue joins its work queue's list when it goes from empty to non-empty, and leaves the list when its last frame is taken.
- R6: An enqueue is dropped when the frame count of its congestion group is already at or above the group threshold. The frame count is the count at the time of the request, before any dequeue in the same cycle. `enq_drop` goes high in the next cycle, and the dropped descriptor never appears at the output.
- R7: An enqueue to a frame queue that already holds FQ_DEPTH frames is dropped in the same way.
- R8: A dequeue request while all work queues are empty gives `deq_ack` high with `deq_valid` low one cycle later. A frame enqueued in the same cycle as that request is not returned by it.
- R9: Every dequeue request is answered exactly one cycle later with `deq_ack`. When a frame is returned, `deq_valid` is high and `deq_fq`/`deq_desc` carry the frame queue index and the descriptor.
- R10: An enqueue and a dequeue can happen in the same cycle. If the dequeued frame queue goes back to the tail and another frame queue joins the same list in that cycle, the returning frame queue goes first. An enqueue to the frame queue being dequeued keeps that frame queue in the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request this cycle |
| enq_fq | input | $clog2(NUM_FQ) | Target frame queue |
| enq_desc | input | DESC_W | Frame descriptor to store |
| enq_drop | output | 1 | Previous cycle's enqueue was discarded |
| deq_req | input | 1 | Dequeue request this cycle |
| deq_ack | output | 1 | Response to previous cycle's dequeue request |
| deq_valid | output | 1 | Response carries a frame |
| deq_fq | output | $clog2(NUM_FQ) | Frame queue the frame came from |
| deq_desc | output | DESC_W | Returned descriptor |

## Verification
The hardest case to reach is a single cycle with three things at once: a frame queue goes back to the tail, a second frame queue joins the same work queue, and that order has to hold on the next two dequeues. The stimulus reaches this with a table step that enqueues to an empty frame queue while dequeuing a frame queue that shares its work queue and still holds a second frame. The later steps then show the order. Other steps enqueue to the frame queue being dequeued when it holds exactly one frame. They also fill work queues in reverse priority order, so that the newest arrival must be served first.

// File: rtl/wq_sched.sv
`timescale 1ns/1ps
module wq_sched #(
  parameter int NUM_FQ   = 8,
  parameter int FQ_DEPTH = 4,
  parameter int DESC_W   = 16,
  parameter int NUM_CG   = 4,
  parameter int CCW      = $clog2(NUM_FQ*FQ_DEPTH+1),
  parameter logic [NUM_FQ*3-1:0] FQ_WQ_MAP = {3'd3,3'd3,3'd7,3'd0,3'd5,3'd5,3'd2,3'd2},
  parameter logic [NUM_FQ*$clog2(NUM_CG)-1:0] FQ_CG_MAP = {2'd3,2'd3,2'd2,2'd2,2'd1,2'd1,2'd0,2'd0},
  parameter logic [NUM_CG*CCW-1:0] CG_THR = {6'd5,6'd32,6'd32,6'd3}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq_valid,
  input  logic [$clog2(NUM_FQ)-1:0] enq_fq,
  input  logic [DESC_W-1:0]         enq_desc,
  output logic                      enq_drop,
  input  logic                      deq_req,
  output logic                      deq_ack,
  output logic                      deq_valid,
  output logic [$clog2(NUM_FQ)-1:0] deq_fq,
  output logic [DESC_W-1:0]         deq_desc
);
  localparam int NWQ = 8;
  localparam int FQW = $clog2(NUM_FQ);
  localparam int DPW = $clog2(FQ_DEPTH);
  localparam int DCW = $clog2(FQ_DEPTH+1);
  localparam int WCW = $clog2(NUM_FQ+1);
  localparam int CGW = $clog2(NUM_CG);

  logic [DESC_W-1:0] fq_mem [NUM_FQ][FQ_DEPTH];
  logic [DPW-1:0]    fq_head [NUM_FQ];
  logic [DCW-1:0]    fq_cnt  [NUM_FQ];
  logic [FQW-1:0]    wq_mem  [NWQ][NUM_FQ];
  logic [FQW-1:0]    wq_head [NWQ];
  logic [WCW-1:0]    wq_cnt  [NWQ];
  logic [CCW-1:0]    cg_cnt  [NUM_CG];

  logic          sel_any;
  logic [2:0]    sel_wq;
  logic [FQW-1:0] sel_fq;
  logic [2:0]    e_wq;
  logic [CGW-1:0] e_cg, s_cg;
  logic          drop, enq_go, deq_go, same, requeue, link;
  logic [DCW-1:0] sel_left;
  logic [NWQ-1:0] wq_pop, wq_pa, wq_pb;
  logic [FQW-1:0] wq_tail [NWQ];

  always_comb begin
    sel_any = 1'b0;
    sel_wq  = '0;
    for (int w = NWQ-1; w >= 0; w--)
      if (wq_cnt[w] != '0) begin
        sel_any = 1'b1;
        sel_wq  = 3'(w);
      end
  end

  assign sel_fq   = wq_mem[sel_wq][wq_head[sel_wq]];
  assign e_wq     = FQ_WQ_MAP[enq_fq*3 +: 3];
  assign e_cg     = FQ_CG_MAP[enq_fq*CGW +: CGW];
  assign s_cg     = FQ_CG_MAP[sel_fq*CGW +: CGW];
  assign drop     = (fq_cnt[enq_fq] == DCW'(FQ_DEPTH)) || (cg_cnt[e_cg] >= CG_THR[e_cg*CCW +: CCW]);
  assign enq_go   = enq_valid && !drop;
  assign deq_go   = deq_req && sel_any;
  assign same     = enq_go && (enq_fq == sel_fq);
  assign sel_left = fq_cnt[sel_fq] - DCW'(1) + DCW'(same);
  assign requeue  = deq_go && (sel_left != '0);
  assign link     = enq_go && (fq_cnt[enq_fq] == '0);

  always_comb
    for (int w = 0; w < NWQ; w++) begin
      wq_pop[w]  = deq_go  && (sel_wq == 3'(w));
      wq_pa[w]   = requeue && (sel_wq == 3'(w));
      wq_pb[w]   = link    && (e_wq == 3'(w));
      wq_tail[w] = wq_head[w] + FQW'(wq_cnt[w]);
    end

  always_ff @(posedge clk) begin
    if (enq_go) fq_mem[enq_fq][fq_head[enq_fq] + DPW'(fq_cnt[enq_fq])] <= enq_desc;
    for (int w = 0; w < NWQ; w++) begin
      if (wq_pa[w]) wq_mem[w][wq_tail[w]] <= sel_fq;
      if (wq_pb[w]) wq_mem[w][wq_tail[w] + FQW'(wq_pa[w])] <= enq_fq;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enq_drop <= 1'b0; deq_ack <= 1'b0; deq_valid <= 1'b0;
      deq_fq <= '0; deq_desc <= '0;
      for (int f = 0; f < NUM_FQ; f++) begin fq_head[f] <= '0; fq_cnt[f] <= '0; end
      for (int w = 0; w < NWQ; w++) begin wq_head[w] <= '0; wq_cnt[w] <= '0; end
      for (int c = 0; c < NUM_CG; c++) cg_cnt[c] <= '0;
    end else begin
      enq_drop  <= enq_valid && drop;
      deq_ack   <= deq_req;
      deq_valid <= deq_go;
      deq_fq    <= sel_fq;
      deq_desc  <= fq_mem[sel_fq][fq_head[sel_fq]];
      if (deq_go) fq_head[sel_fq] <= fq_head[sel_fq] + DPW'(1);
      for (int f = 0; f < NUM_FQ; f++)
        fq_cnt[f] <= fq_cnt[f] + DCW'(enq_go && enq_fq == FQW'(f)) - DCW'(deq_go && sel_fq == FQW'(f));
      for (int c = 0; c < NUM_CG; c++)
        cg_cnt[c] <= cg_cnt[c] + CCW'(enq_go && e_cg == CGW'(c)) - CCW'(deq_go && s_cg == CGW'(c));
      for (int w = 0; w < NWQ; w++) begin
        if (wq_pop[w]) wq_head[w] <= wq_head[w] + FQW'(1);
        wq_cnt[w] <= wq_cnt[w] + WCW'(wq_pa[w]) + WCW'(wq_pb[w]) - WCW'(wq_pop[w]);
      end
    end
  end

  int nz_fq, wq_total;
  always_comb begin
    nz_fq = 0; wq_total = 0;
    for (int f = 0; f < NUM_FQ; f++) if (fq_cnt[f] != '0) nz_fq++;
    for (int w = 0; w < NWQ; w++) wq_total += int'(wq_cnt[w]);
  end

  // R5
  link_match_chk: assert property (@(posedge clk) disable iff (!rst_n) nz_fq == wq_total);

  // R8
  empty_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (deq_req && wq_total == 0) |=> (deq_ack && !deq_valid));

  // R9
  deq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n) deq_req |=> deq_ack);

  for (genvar g = 0; g < NUM_CG; g++) begin : g_cg
    // R6
    cg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cg_cnt[g] <= CG_THR[g*CCW +: CCW]);
  end

  for (genvar g = 0; g < NUM_FQ; g++) begin : g_fq
    // R7
    fq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fq_cnt[g] <= DCW'(FQ_DEPTH));
  end
endmodule

// File: tb/wq_sched_tb.sv
`timescale 1ns/1ps
module wq_sched_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enq_valid = 1'b0, deq_req = 1'b0;
  logic [2:0] enq_fq = '0;
  logic [15:0] enq_desc = '0;
  logic enq_drop, deq_ack, deq_valid;
  logic [2:0] deq_fq;
  logic [15:0] deq_desc;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wq_sched u_dut (.clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_fq(enq_fq),
    .enq_desc(enq_desc), .enq_drop(enq_drop), .deq_req(deq_req), .deq_ack(deq_ack),
    .deq_valid(deq_valid), .deq_fq(deq_fq), .deq_desc(deq_desc));

  // Maps under test: fq0,1->wq2 cg0(thr 3); fq2,3->wq5 cg1; fq4->wq0 cg2; fq5->wq7 cg2; fq6,7->wq3 cg3(thr 5)
  typedef struct packed {
    logic ev; logic [2:0] efq; logic [15:0] ed; logic dv;
    logic xdrop; logic xval; logic [2:0] xfq; logic [15:0] xd; logic [3:0] rq;
  } step_t;

  localparam int NSTEP = 44;
  localparam step_t TBL [NSTEP] = '{
    '{0,0,16'h000,1, 0,0,0,16'h000, 8},  // R8 empty
    '{1,0,16'h100,0, 0,0,0,16'h000, 4},
    '{1,1,16'h110,0, 0,0,0,16'h000, 4},
    '{1,0,16'h101,0, 0,0,0,16'h000, 4},
    '{1,1,16'h111,0, 1,0,0,16'h000, 6},  // R6 cg0 at 3
    '{1,2,16'h200,0, 0,0,0,16'h000, 5},
    '{1,4,16'h400,0, 0,0,0,16'h000, 5},
    '{0,0,16'h000,1, 0,1,4,16'h400, 2},  // R2 wq0 first
    '{0,0,16'h000,1, 0,1,0,16'h100, 3},  // R3
    '{0,0,16'h000,1, 0,1,1,16'h110, 3},
    '{1,1,16'h112,0, 0,0,0,16'h000, 6},  // R6 room again after dequeues
    '{0,0,16'h000,1, 0,1,0,16'h101, 4},  // R4
    '{0,0,16'h000,1, 0,1,1,16'h112, 6},  // R6 dropped 111 never seen
    '{0,0,16'h000,1, 0,1,2,16'h200, 5},  // R5 drained wq2
    '{0,0,16'h000,1, 0,0,0,16'h000, 8},
    '{1,6,16'h600,0, 0,0,0,16'h000, 7},
    '{1,6,16'h601,0, 0,0,0,16'h000, 7},
    '{1,6,16'h602,0, 0,0,0,16'h000, 7},
    '{1,6,16'h603,0, 0,0,0,16'h000, 7},
    '{1,6,16'h604,0, 1,0,0,16'h000, 7},  // R7 fq full
    '{1,7,16'h700,0, 0,0,0,16'h000, 6},
    '{1,7,16'h701,0, 1,0,0,16'h000, 6},  // R6 cg3 at 5
    '{0,0,16'h000,1, 0,1,6,16'h600, 3},
    '{0,0,16'h000,1, 0,1,7,16'h700, 3},
    '{0,0,16'h000,1, 0,1,6,16'h601, 5},  // R5 fq7 unlinked
    '{0,0,16'h000,1, 0,1,6,16'h602, 4},
    '{0,0,16'h000,1, 0,1,6,16'h603, 7},  // R7 604 never stored
    '{0,0,16'h000,1, 0,0,0,16'h000, 8},
    '{1,0,16'h130,0, 0,0,0,16'h000, 10},
    '{1,0,16'h131,0, 0,0,0,16'h000, 10},
    '{1,1,16'h132,1, 0,1,0,16'h130, 10}, // R10 requeue + link same wq
    '{0,0,16'h000,1, 0,1,0,16'h131, 10},
    '{0,0,16'h000,1, 0,1,1,16'h132, 10},
    '{1,5,16'h500,1, 0,0,0,16'h000, 8},  // R8 same-cycle enqueue not seen
    '{1,5,16'h501,1, 0,1,5,16'h500, 10}, // R10 enqueue to dequeued fq
    '{0,0,16'h000,1, 0,1,5,16'h501, 10},
    '{0,0,16'h000,1, 0,0,0,16'h000, 8},
    '{1,5,16'h502,0, 0,0,0,16'h000, 2},
    '{1,2,16'h202,0, 0,0,0,16'h000, 2},
    '{1,4,16'h402,0, 0,0,0,16'h000, 2},
    '{0,0,16'h000,1, 0,1,4,16'h402, 2},  // R2
    '{0,0,16'h000,1, 0,1,2,16'h202, 2},
    '{0,0,16'h000,1, 0,1,5,16'h502, 2},
    '{0,0,16'h000,1, 0,0,0,16'h000, 9}   // R9
  };

  task automatic chk(input bit ok, input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input step_t s);
    enq_valid = s.ev; enq_fq = s.efq; enq_desc = s.ed; deq_req = s.dv;
    @(negedge clk);
    enq_valid = 1'b0; deq_req = 1'b0;
    chk(enq_drop === s.xdrop, int'(s.rq), "enq_drop", 32'(enq_drop), 32'(s.xdrop));
    chk(deq_ack === s.dv, 9, "deq_ack", 32'(deq_ack), 32'(s.dv));
    chk(deq_valid === s.xval, int'(s.rq), "deq_valid", 32'(deq_valid), 32'(s.xval));
    if (s.xval)
      chk(deq_fq === s.xfq && deq_desc === s.xd, int'(s.rq), "fq/desc",
          {13'd0, deq_fq, deq_desc}, {13'd0, s.xfq, s.xd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!enq_drop && !deq_ack && !deq_valid, 1, "outputs after reset",
        {29'd0, enq_drop, deq_ack, deq_valid}, 32'd0);
    for (int i = 0; i < NSTEP; i++) step(TBL[i]);
    // R1 reset in mid-run clears queues
    step('{1,3,16'h333,0, 0,0,0,16'h000, 1});
    rst_n = 1'b0;
    @(negedge clk);
    chk(!deq_ack && !deq_valid, 1, "outputs in reset", {30'd0, deq_ack, deq_valid}, 32'd0);
    rst_n = 1'b1;
    step('{0,0,16'h000,1, 0,0,0,16'h000, 1});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule